// File: doc/BRIEF.md
# Segment Access Permission Checker

This block screens every memory access made through a segment before the access reaches address translation. For each request it takes the segment index, the selector currently held for that segment, the segment's cached attribute bits, base and limit, plus the access type, offset and access size. One clock later it returns a fault flag, a fault cause code and the linear address (base plus offset).

Segment indices 0 up to `LAST_DATA_IDX` are the data-class segment registers. Only these have their writable and readable bits checked and their expand-down bit honoured. Every other index, such as the descriptor-table and system registers, gets the null-selector test and a plain upward limit test.

The faults follow a fixed priority. A null selector wins over the permission checks, and the permission checks win over the limit check. Any fault reported here stands for a general-protection fault with error code zero. Delivering that fault is left to the consumer.

Top module: `segchk_top`

## Requirements
- R1: A request presented with `reqValid` high produces `respValid` high on the following clock, together with its result. In a cycle after no request, `respValid` and `fault` are low. Reset clears `respValid`, `fault`, `faultKind` and `linAddr` to zero.
- R2: When the selector is zero, the result is `faultKind` = 1 (null selector). This holds for every segment index and every access type.
- R3: A write (`accType` = 01) through a data-class index (index <= `LAST_DATA_IDX`, default 6) whose writable bit (`segAttr[1]`) is clear gives `faultKind` = 2.
- R4: A data read (`accType` = 00, or the reserved code 11) through a data-class index whose readable bit (`segAttr[0]`) is clear gives `faultKind` = 3. An instruction fetch (`accType` = 10) is never subject to the readable check.
- R5: For indices above `LAST_DATA_IDX`, the writable and readable bits are ignored. The expand-down bit (`segAttr[2]`) is also treated as clear for these indices.
- R6: For a segment that is not expand-down, the last byte touched is `accOffset + accSizeM1`, where `accSizeM1` is the access size minus one. This sum is computed one bit wider than the address, so it never wraps. The result is `faultKind` = 4 when that last byte exceeds `segLimit`.
- R7: For an expand-down data-class segment, the result is `faultKind` = 4 when `accOffset <= segLimit`. Offsets above the limit pass.
- R8: Priority is null selector (1) over permission (2 or 3) over limit (4). Only the winning cause is reported.
- R9: `linAddr` is `segBase + accOffset` modulo 2^`ADDR_W`, and it is presented whether or not the access faults.
- R10: `faultKind` = 0 means no fault. `fault` is high exactly when a responded request has a nonzero `faultKind`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| segIdx | input | IDX_W | Segment register index |
| selector | input | SEL_W | Selector held for that segment |
| segAttr | input | 3 | bit0 readable, bit1 writable, bit2 expand-down |
| segBase | input | ADDR_W | Segment base |
| segLimit | input | ADDR_W | Segment limit |
| accType | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| accOffset | input | ADDR_W | Offset within segment |
| accSizeM1 | input | 3 | Access size in bytes minus one |
| respValid | output | 1 | Result valid |
| fault | output | 1 | Access faults |
| faultKind | output | 3 | 0 none, 1 null, 2 write, 3 read, 4 limit |
| linAddr | output | ADDR_W | Linear address |

## Verification
The bench targets the exact limit edge in both directions. In the normal direction, the last byte equal to the limit passes and one byte beyond faults. In the expand-down direction, the offset equal to the limit faults and the offset one above passes. A design that compared the wrong side, or used `<` where `<=` is needed, would flip one of these results.

A request near the top of the address space with an all-ones limit exposes an end-address sum that wraps to a small value and lets the access through. Accesses through indices above the data class carry clear permission bits and a set expand-down bit. A design that applied those bits everywhere would report write, read or limit faults there.

Combined-cause requests show whether the priority is kept, where a wrong design would report the lower cause. Fetches through unreadable segments catch a design that treats every non-write as a data read.

// File: rtl/segchk_pkg.sv
package segchk_pkg;

  typedef enum logic [2:0] {
    FK_NONE  = 3'd0,
    FK_NULL  = 3'd1,
    FK_WPROT = 3'd2,
    FK_RPROT = 3'd3,
    FK_LIMIT = 3'd4
  } faultKind_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } accType_e;

  localparam int ATTR_RD = 0;
  localparam int ATTR_WR = 1;
  localparam int ATTR_ED = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic nullSel;
    logic permWrite;
    logic permRead;
    logic useExpandDown;
  } ctrlStrobes_t;

endpackage

// File: rtl/segchk_ctrl.sv
module segchk_ctrl
  import segchk_pkg::*;
#(
  parameter int IDX_W         = 4,
  parameter int SEL_W         = 16,
  parameter int LAST_DATA_IDX = 6
) (
  input  logic [IDX_W-1:0] segIdx,
  input  logic [SEL_W-1:0] selector,
  input  logic [2:0]       segAttr,
  input  logic [1:0]       accType,
  output ctrlStrobes_t     strobes
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LAST_DATA_IDX);

  logic isDataClass;
  logic isWrite;
  logic isFetch;
  logic isRead;

  always_comb begin
    isDataClass = (segIdx <= LAST_IDX);
    isWrite     = (accType == ACC_WRITE);
    isFetch     = (accType == ACC_FETCH);
    isRead      = !isWrite && !isFetch;

    strobes.nullSel       = (selector == '0);
    strobes.permWrite     = isDataClass && isWrite && !segAttr[ATTR_WR];
    strobes.permRead      = isDataClass && isRead  && !segAttr[ATTR_RD];
    strobes.useExpandDown = isDataClass && segAttr[ATTR_ED];
  end

endmodule

// File: rtl/segchk_dp.sv
module segchk_dp
  import segchk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] segBase,
  input  logic [ADDR_W-1:0] segLimit,
  input  logic [ADDR_W-1:0] accOffset,
  input  logic [2:0]        accSizeM1,
  output logic              respValid,
  output logic              fault,
  output logic [2:0]        faultKind,
  output logic [ADDR_W-1:0] linAddr
);

  localparam int WIDE_W = ADDR_W + 1;

  logic [WIDE_W-1:0] lastByte;
  logic              limitBad;
  faultKind_e        kindNext;
  logic [ADDR_W-1:0] linNext;

  always_comb begin
    lastByte = {1'b0, accOffset} + WIDE_W'(accSizeM1);
    if (strobes.useExpandDown)
      limitBad = (accOffset <= segLimit);
    else
      limitBad = (lastByte > {1'b0, segLimit});

    if (strobes.nullSel)
      kindNext = FK_NULL;
    else if (strobes.permWrite)
      kindNext = FK_WPROT;
    else if (strobes.permRead)
      kindNext = FK_RPROT;
    else if (limitBad)
      kindNext = FK_LIMIT;
    else
      kindNext = FK_NONE;

    linNext = segBase + accOffset;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      respValid <= 1'b0;
      fault     <= 1'b0;
      faultKind <= FK_NONE;
      linAddr   <= '0;
    end else begin
      respValid <= reqValid;
      if (reqValid) begin
        fault     <= (kindNext != FK_NONE);
        faultKind <= kindNext;
        linAddr   <= linNext;
      end else begin
        fault     <= 1'b0;
        faultKind <= FK_NONE;
      end
    end
  end

endmodule

// File: rtl/segchk_top.sv
module segchk_top
  import segchk_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int SEL_W         = 16,
  parameter int IDX_W         = 4,
  parameter int LAST_DATA_IDX = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [IDX_W-1:0]  segIdx,
  input  logic [SEL_W-1:0]  selector,
  input  logic [2:0]        segAttr,
  input  logic [ADDR_W-1:0] segBase,
  input  logic [ADDR_W-1:0] segLimit,
  input  logic [1:0]        accType,
  input  logic [ADDR_W-1:0] accOffset,
  input  logic [2:0]        accSizeM1,
  output logic              respValid,
  output logic              fault,
  output logic [2:0]        faultKind,
  output logic [ADDR_W-1:0] linAddr
);

  ctrlStrobes_t strobes;

  segchk_ctrl #(
    .IDX_W(IDX_W), .SEL_W(SEL_W), .LAST_DATA_IDX(LAST_DATA_IDX)
  ) u_ctrl (
    .segIdx(segIdx), .selector(selector), .segAttr(segAttr),
    .accType(accType), .strobes(strobes)
  );

  segchk_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .strobes(strobes),
    .segBase(segBase), .segLimit(segLimit), .accOffset(accOffset),
    .accSizeM1(accSizeM1), .respValid(respValid), .fault(fault),
    .faultKind(faultKind), .linAddr(linAddr)
  );

endmodule

// File: rtl/segchk_sva.sv
module segchk_sva #(
  parameter int ADDR_W        = 32,
  parameter int SEL_W         = 16,
  parameter int IDX_W         = 4,
  parameter int LAST_DATA_IDX = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic [IDX_W-1:0]  segIdx,
  input logic [SEL_W-1:0]  selector,
  input logic [2:0]        segAttr,
  input logic [ADDR_W-1:0] segBase,
  input logic [ADDR_W-1:0] segLimit,
  input logic [1:0]        accType,
  input logic [ADDR_W-1:0] accOffset,
  input logic              respValid,
  input logic              fault,
  input logic [2:0]        faultKind,
  input logic [ADDR_W-1:0] linAddr
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LAST_DATA_IDX);

  AST_RESP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> respValid); // R1

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> (!respValid && !fault)); // R1

  AST_NULL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && selector == '0) |=> (faultKind == 3'd1 && fault)); // R2

  AST_WRITE_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && selector != '0 && segIdx <= LAST_IDX && accType == 2'b01 && !segAttr[1])
      |=> (faultKind == 3'd2)); // R3

  AST_FETCH_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && accType == 2'b10) |=> (faultKind != 3'd3)); // R4

  AST_NONDATA_NO_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && segIdx > LAST_IDX) |=> (faultKind != 3'd2 && faultKind != 3'd3)); // R5

  AST_EXPDOWN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && selector != '0 && segIdx <= LAST_IDX && accType == 2'b10 &&
     segAttr[2] && accOffset <= segLimit) |=> (faultKind == 3'd4)); // R7

  AST_LIN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> (linAddr == $past(segBase + accOffset))); // R9

endmodule

bind segchk_top segchk_sva #(
  .ADDR_W(ADDR_W), .SEL_W(SEL_W), .IDX_W(IDX_W), .LAST_DATA_IDX(LAST_DATA_IDX)
) u_sva (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .segIdx(segIdx),
  .selector(selector), .segAttr(segAttr), .segBase(segBase),
  .segLimit(segLimit), .accType(accType), .accOffset(accOffset),
  .respValid(respValid), .fault(fault), .faultKind(faultKind),
  .linAddr(linAddr)
);

// File: tb/segchk_top_tb.sv
`timescale 1ns/1ps
module segchk_top_tb;

  localparam int ADDR_W = 32;
  localparam int SEL_W  = 16;
  localparam int IDX_W  = 4;
  localparam int LAST   = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reqValid = 1'b0;
  logic [IDX_W-1:0]  segIdx = '0;
  logic [SEL_W-1:0]  selector = '0;
  logic [2:0]        segAttr = '0;
  logic [ADDR_W-1:0] segBase = '0;
  logic [ADDR_W-1:0] segLimit = '0;
  logic [1:0]        accType = '0;
  logic [ADDR_W-1:0] accOffset = '0;
  logic [2:0]        accSizeM1 = '0;
  logic              respValid;
  logic              fault;
  logic [2:0]        faultKind;
  logic [ADDR_W-1:0] linAddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // expected result of the request driven in the previous cycle
  bit              expValid = 1'b0;
  int              expKind  = 0;
  logic [ADDR_W-1:0] expLin = '0;

  always #2 clk = ~clk;

  segchk_top #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .IDX_W(IDX_W), .LAST_DATA_IDX(LAST)) u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .segIdx(segIdx),
    .selector(selector), .segAttr(segAttr), .segBase(segBase),
    .segLimit(segLimit), .accType(accType), .accOffset(accOffset),
    .accSizeM1(accSizeM1), .respValid(respValid), .fault(fault),
    .faultKind(faultKind), .linAddr(linAddr)
  );

  function automatic int refKind(int idx, int sel, int attr, longint lim,
                                 int typ, longint off, int sm1);
    bit dataCls = (idx <= LAST);
    bit expDown = dataCls && attr[2];
    if (sel == 0) return 1;
    if (dataCls && typ == 1 && attr[1] == 0) return 2;
    if (dataCls && (typ == 0 || typ == 3) && attr[0] == 0) return 3;
    if (expDown) begin
      if (off <= lim) return 4;
    end else if (off + sm1 > lim) return 4;
    return 0;
  endfunction

  task automatic compare(string tag);
    checks++;
    if (respValid !== expValid) begin
      fails++;
      $display("FAIL %s respValid actual %0b expected %0b", tag, respValid, expValid);
    end else if (expValid) begin
      if (faultKind !== 3'(expKind) || fault !== (expKind != 0)) begin
        fails++;
        $display("FAIL %s kind/fault actual %0d/%0b expected %0d/%0b",
                 tag, faultKind, fault, expKind, expKind != 0);
      end
      if (linAddr !== expLin) begin
        fails++;
        $display("FAIL %s linAddr actual %h expected %h", tag, linAddr, expLin);
      end
    end else if (fault !== 1'b0) begin
      fails++;
      $display("FAIL %s idle fault actual %0b expected 0", tag, fault);
    end
  endtask

  // drive at negedge, check one cycle later at negedge
  task automatic step(bit v, int idx, int sel, int attr, logic [ADDR_W-1:0] base,
                      logic [ADDR_W-1:0] lim, int typ, logic [ADDR_W-1:0] off,
                      int sm1, string tag);
    reqValid  = v;
    segIdx    = IDX_W'(idx);
    selector  = SEL_W'(sel);
    segAttr   = 3'(attr);
    segBase   = base;
    segLimit  = lim;
    accType   = 2'(typ);
    accOffset = off;
    accSizeM1 = 3'(sm1);
    @(negedge clk);
    expValid = v;
    if (v) begin
      expKind = refKind(idx, sel, attr, longint'(lim), typ, longint'(off), sm1);
      expLin  = base + off;
    end
    compare(tag);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (respValid !== 1'b0 || fault !== 1'b0 || faultKind !== 3'd0 || linAddr !== '0) begin
      fails++;
      $display("FAIL R1 reset actual %0b/%0b/%0d/%h expected 0/0/0/0",
               respValid, fault, faultKind, linAddr);
    end
    rst_n = 1'b1;

    // R9 R6 in-range read, linear address
    step(1, 3, 8, 3'b011, 32'h1000, 32'hFF, 0, 32'hF0, 3, "R9_R6_inrange");
    // R6 exact last byte and one over
    step(1, 3, 8, 3'b011, 32'h0, 32'hFF, 0, 32'hFC, 3, "R6_edge_ok");
    step(1, 3, 8, 3'b011, 32'h0, 32'hFF, 0, 32'hFD, 3, "R6_edge_over");
    // R6 no wrap of the end address
    step(1, 4, 8, 3'b011, 32'h10, 32'hFFFFFFFF, 0, 32'hFFFFFFFE, 3, "R6_nowrap");
    // R1 idle cycle
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1_idle");
    // R3 write protection
    step(1, 0, 8, 3'b001, 32'h0, 32'hFFFF, 1, 32'h10, 0, "R3_wprot");
    step(1, 0, 8, 3'b011, 32'h0, 32'hFFFF, 1, 32'h10, 0, "R3_wok");
    // R4 read protection and fetch exemption
    step(1, 5, 8, 3'b010, 32'h0, 32'hFFFF, 0, 32'h10, 0, "R4_rprot");
    step(1, 6, 8, 3'b010, 32'h0, 32'hFFFF, 3, 32'h10, 0, "R4_rsvd_read");
    step(1, 1, 8, 3'b000, 32'h0, 32'hFFFF, 2, 32'h10, 0, "R4_fetch");
    // R5 non-data indices skip perms and expand-down
    step(1, 7, 8, 3'b000, 32'h0, 32'hFFFF, 1, 32'h10, 0, "R5_nowrite");
    step(1, 8, 8, 3'b100, 32'h0, 32'hFFFF, 0, 32'h10, 1, "R5_noexpdown");
    // R7 expand-down edges
    step(1, 2, 8, 3'b111, 32'h0, 32'h1000, 0, 32'h1000, 0, "R7_at_limit");
    step(1, 2, 8, 3'b111, 32'h0, 32'h1000, 1, 32'h1001, 3, "R7_above");
    // R2 null selector on a non-data index
    step(1, 9, 0, 3'b111, 32'h0, 32'hFFFF, 2, 32'h10, 0, "R2_null");
    // R8 priority
    step(1, 0, 0, 3'b000, 32'h0, 32'h0, 1, 32'h100, 7, "R8_null_over_all");
    step(1, 0, 8, 3'b000, 32'h0, 32'h0, 1, 32'h100, 7, "R8_perm_over_limit");
    step(1, 0, 8, 3'b001, 32'h0, 32'h0, 0, 32'h100, 7, "R8_limit_last");

    // R10 mixed traffic compared every clock
    for (int i = 0; i < 400; i++) begin
      int lim = (i % 3 == 0) ? 32'h100 : int'($urandom);
      int off = (i % 3 == 0) ? 32'hF8 + ($urandom % 16) : int'($urandom);
      step($urandom % 4 != 0, $urandom % 12, ($urandom % 5 == 0) ? 0 : $urandom,
           $urandom % 8, $urandom, lim, $urandom % 4, off, $urandom % 8, "R10_mix");
    end
    finishRun();
  end

endmodule